// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block chooses which of 82 interrupt request lines a processor core should service next. It tells the core whether such a request exists and gives the address it should jump to. Each request line has its own priority level from 0 to 3, and software sets these levels through a simple register write port. The core supplies a 2-bit mask that gives the lowest level it will currently accept. The core raises this mask while it services an exception, so only requests at the same level or above can nest on top of the one in progress.

Arbitration has two steps. First, the block takes the highest level that the mask allows and that has any active request. Second, within that level, it takes the request line with the lowest number. The block forms the jump address by placing a 14-bit base register above the 7-bit number of the winning line. It also raises a wake signal for the clock control logic when a permitted request is pending while the system is in a low-power state. All outputs are registered.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_o`, `wake_o`, `lvl_o` and `vec_o` are all zero. Reset clears every line's level to 0 and clears the base to 0.
- R2: When `cfg_we_i` is high, the address selects the target. An address from 0 to 81 stores `cfg_wdata_i[1:0]` as that line's level. Address 82 stores `cfg_wdata_i[13:0]` as the vector base. Addresses 83 to 127 change nothing. A write made at clock edge k first affects outputs after edge k+1.
- R3: A level L is permitted when L is greater than or equal to the value of `mask_i`. So mask 0 accepts levels 0 to 3, mask 1 accepts 1 to 3, mask 2 accepts 2 and 3, and mask 3 accepts only level 3. An active line at a level that is not permitted never wins.
- R4: Among the permitted levels, the highest level that has at least one active line is chosen, and `lvl_o` shows that level.
- R5: Within the chosen level, the active line with the lowest number wins. Line 0 ranks first and line 81 ranks last.
- R6: `vec_o[20:7]` is the vector base and `vec_o[6:0]` is the number of the winning line. Both are taken in the same cycle as the request lines.
- R7: `req_o` is 1 exactly when at least one active line sits at a permitted level. When `req_o` is 0, `lvl_o` is 0 and `vec_o[6:0]` is 0.
- R8: `wake_o` is 1 exactly when `lowpwr_i` was 1 and a permitted request existed in the same sampled cycle.
- R9: Every output reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | 82 | Request lines; bit n is line n |
| mask_i | input | 2 | Core mask: the lowest level the core currently accepts |
| lowpwr_i | input | 1 | System is in a wait or stop state |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 7 | 0 to 81 selects a line's level, 82 selects the base |
| cfg_wdata_i | input | 14 | Write data |
| req_o | output | 1 | A permitted request is pending |
| lvl_o | output | 2 | Level of the winning line |
| vec_o | output | 21 | Jump address: base above the line number |
| wake_o | output | 1 | Restart clocks out of the low-power state |

## Verification
A configuration write can land in the same cycle as an arbitration that uses the register being written. For example, the level of the line that is currently winning may change, or the base may change while a request is pending. The bench provokes this on purpose: it rewrites the level of an active winning line and the base while requests are held. It then expects the old setting to govern the output of that cycle and the new setting to govern the following one. Randomized traffic then mixes writes, mask changes and low-power toggles, and a behavioural model compares every output on every clock.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
    localparam int IPC_NUM_SRC = 82;
    localparam int IPC_NUM_LVL = 4;
    localparam int IPC_LVL_W   = $clog2(IPC_NUM_LVL);
    localparam int IPC_BASE_W  = 14;
    localparam int IPC_SRC_W   = $clog2(IPC_NUM_SRC);
    localparam int IPC_ADDR_W  = $clog2(IPC_NUM_SRC + 1);
    localparam int IPC_VEC_W   = IPC_BASE_W + IPC_SRC_W;

    typedef logic [IPC_LVL_W-1:0] lvl_t;
    typedef logic [IPC_SRC_W-1:0] src_t;

    // One arbitration decision, registered as a unit
    typedef struct packed {
        logic  req;
        logic  wake;
        lvl_t  lvl;
        logic [IPC_BASE_W-1:0] base;
        src_t  src;
    } ipc_dec_t;

    // A level is accepted when it is at or above the core mask
    function automatic logic lvl_allowed(input lvl_t lvl, input lvl_t mask);
        return lvl >= mask;
    endfunction
endpackage

// File: rtl/ipc_cfg_regs.sv
module ipc_cfg_regs
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = IPC_NUM_SRC,
    parameter int LVL_W   = IPC_LVL_W,
    parameter int BASE_W  = IPC_BASE_W,
    parameter int ADDR_W  = IPC_ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [BASE_W-1:0]             wdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_tab,
    output logic [BASE_W-1:0]             base
);
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(NUM_SRC);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst)
                lvl_tab[s] <= '0;
            else if (we && addr == ADDR_W'(s))
                lvl_tab[s] <= wdata[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            base <= '0;
        else if (we && addr == BASE_ADDR)
            base <= wdata;
    end

    AST_BASE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (we && addr == BASE_ADDR) |=> base == $past(wdata)); // R2
    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (we && addr > BASE_ADDR) |=> ($stable(base) && $stable(lvl_tab))); // R2
endmodule

// File: rtl/ipc_level_pick.sv
module ipc_level_pick
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = IPC_NUM_SRC,
    parameter int NUM_LVL = IPC_NUM_LVL,
    parameter int LVL_W   = IPC_LVL_W
) (
    input  logic [NUM_SRC-1:0]            irq,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_tab,
    input  logic [LVL_W-1:0]              mask,
    output logic                          found,
    output logic [LVL_W-1:0]              win_lvl
);
    logic [NUM_LVL-1:0] hit;

    // Per level: is any active line assigned to it
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_hit
        always_comb begin
            hit[l] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++)
                if (irq[s] && lvl_tab[s] == LVL_W'(l))
                    hit[l] = 1'b1;
        end
    end

    // Highest accepted level with a hit; later iterations override
    always_comb begin
        found   = 1'b0;
        win_lvl = '0;
        for (int l = 0; l < NUM_LVL; l++)
            if (hit[l] && lvl_allowed(LVL_W'(l), mask)) begin
                found   = 1'b1;
                win_lvl = LVL_W'(l);
            end
    end
endmodule

// File: rtl/ipc_src_find.sv
module ipc_src_find
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = IPC_NUM_SRC,
    parameter int LVL_W   = IPC_LVL_W,
    parameter int SRC_W   = IPC_SRC_W
) (
    input  logic [NUM_SRC-1:0]            irq,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_tab,
    input  logic [LVL_W-1:0]              sel_lvl,
    output logic [SRC_W-1:0]              src
);
    logic [NUM_SRC-1:0] member;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_mem
        assign member[s] = irq[s] && (lvl_tab[s] == sel_lvl);
    end

    // Scan downward so the lowest-numbered member is written last
    always_comb begin
        src = '0;
        for (int s = NUM_SRC - 1; s >= 0; s--)
            if (member[s])
                src = SRC_W'(s);
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import ipc_pkg::*;
#(
    parameter int NUM_SRC = IPC_NUM_SRC,
    parameter int NUM_LVL = IPC_NUM_LVL,
    parameter int LVL_W   = IPC_LVL_W,
    parameter int BASE_W  = IPC_BASE_W,
    parameter int SRC_W   = IPC_SRC_W,
    parameter int ADDR_W  = IPC_ADDR_W,
    parameter int VEC_W   = BASE_W + SRC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_i,
    input  logic [LVL_W-1:0]   mask_i,
    input  logic               lowpwr_i,
    input  logic               cfg_we_i,
    input  logic [ADDR_W-1:0]  cfg_addr_i,
    input  logic [BASE_W-1:0]  cfg_wdata_i,
    output logic               req_o,
    output logic [LVL_W-1:0]   lvl_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_tab;
    logic [BASE_W-1:0]             base;
    logic                          found;
    logic [LVL_W-1:0]              win_lvl;
    logic [SRC_W-1:0]              win_src;
    ipc_dec_t                      dec_d, dec_q;

    ipc_cfg_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) cfg_i (
        .clk(clk), .rst(rst), .we(cfg_we_i), .addr(cfg_addr_i), .wdata(cfg_wdata_i),
        .lvl_tab(lvl_tab), .base(base)
    );

    ipc_level_pick #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) pick_i (
        .irq(irq_i), .lvl_tab(lvl_tab), .mask(mask_i), .found(found), .win_lvl(win_lvl)
    );

    ipc_src_find #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .SRC_W(SRC_W)) find_i (
        .irq(irq_i), .lvl_tab(lvl_tab), .sel_lvl(win_lvl), .src(win_src)
    );

    always_comb begin
        dec_d.req  = found;
        dec_d.wake = found && lowpwr_i;
        dec_d.lvl  = found ? win_lvl : '0;
        dec_d.src  = found ? win_src : '0;
        dec_d.base = base;
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign req_o  = dec_q.req;
    assign wake_o = dec_q.wake;
    assign lvl_o  = dec_q.lvl;
    assign vec_o  = {dec_q.base, dec_q.src};

    AST_REQ_LEVEL_ALLOWED: assert property (@(posedge clk) disable iff (rst)
        req_o |-> lvl_o >= $past(mask_i)); // R3
    AST_WINNER_WAS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        req_o |-> |(($past(irq_i) >> vec_o[SRC_W-1:0]) & NUM_SRC'(1))); // R5
    AST_NO_REQ_WHEN_QUIET: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_i) == '0) |-> !req_o); // R7
    AST_IDLE_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !req_o |-> (lvl_o == '0 && vec_o[SRC_W-1:0] == '0)); // R7
    AST_WAKE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (req_o && $past(lowpwr_i))); // R8
endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int NS = 82;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [NS-1:0] irq = '0;
    logic [1:0]  mask = 2'd0;
    logic        lp = 1'b0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [13:0] wdata = '0;
    logic        req_o, wake_o;
    logic [1:0]  lvl_o;
    logic [20:0] vec_o;

    int tests = 0, fails = 0;
    bit done = 0, have_exp = 0;
    string tag = "R1";

    // behavioural reference state
    int m_lvl[NS];
    int m_base;
    int e_req, e_lvl, e_vec, e_wake;

    always #10 clk = ~clk;

    prio_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .irq_i(irq), .mask_i(mask), .lowpwr_i(lp),
        .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
        .req_o(req_o), .lvl_o(lvl_o), .vec_o(vec_o), .wake_o(wake_o)
    );

    // Reference: evaluate with the settings held before this edge, then apply writes
    always @(posedge clk) begin
        if (rst) begin
            e_req = 0; e_lvl = 0; e_vec = 0; e_wake = 0;
            m_base = 0;
            foreach (m_lvl[i]) m_lvl[i] = 0;
        end else begin
            int w_src;
            w_src = -1;
            e_req = 0; e_lvl = 0;
            for (int l = 3; l >= int'(mask) && w_src < 0; l--)
                for (int s = 0; s < NS && w_src < 0; s++)
                    if (irq[s] && m_lvl[s] == l) begin
                        w_src = s; e_lvl = l; e_req = 1;
                    end
            e_vec  = m_base * 128 + (w_src < 0 ? 0 : w_src);
            e_wake = (lp && e_req) ? 1 : 0;
            if (we) begin
                if (addr < 7'd82) m_lvl[addr] = int'(wdata[1:0]);
                else if (addr == 7'd82) m_base = int'(wdata);
            end
        end
        have_exp = 1;
    end

    task automatic chk(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output on every clock, away from the active edge (R9 timing)
    always @(negedge clk) if (have_exp && !done) begin
        chk("R7/R9 req", int'(req_o), e_req);
        chk("R4 lvl", int'(lvl_o), e_lvl);
        chk("R5/R6 vec", int'(vec_o), e_vec);
        chk("R8 wake", int'(wake_o), e_wake);
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        we = 1'b1; addr = 7'(a); wdata = 14'(d);
        step(1);
        we = 1'b0;
    endtask

    task automatic set_irq(input int a, input int b, input int c, input int d);
        irq = '0;
        if (a >= 0) irq[a] = 1'b1;
        if (b >= 0) irq[b] = 1'b1;
        if (c >= 0) irq[c] = 1'b1;
        if (d >= 0) irq[d] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tag = "R1";
        irq = '1; mask = 2'd0; lp = 1'b1;
        step(4);
        chk("R1 reset req", int'(req_o), 0);
        chk("R1 reset vec", int'(vec_o), 0);
        chk("R1 reset wake", int'(wake_o), 0);
        irq = '0; lp = 1'b0;
        rst = 1'b0;
        step(1);
        chk("R1 first cycle lvl", int'(lvl_o), 0);

        tag = "R2";
        wr(5, 2); wr(10, 2); wr(40, 3); wr(81, 1); wr(0, 0);
        wr(82, 'h1ABC);
        wr(100, 'h3FFF);   // ignored address
        wr(127, 'h3FFF);   // ignored address
        step(2);

        tag = "R5";
        set_irq(10, 5, -1, -1); step(3);
        tag = "R4";
        set_irq(10, 5, 81, 40); step(3);
        set_irq(10, 5, 81, -1); step(3);
        set_irq(81, 0, -1, -1); step(3);

        tag = "R3";
        set_irq(10, 5, 81, 40); mask = 2'd3; step(3);
        set_irq(10, 5, 81, -1); step(3);
        mask = 2'd2; step(3);
        set_irq(81, 0, -1, -1); mask = 2'd1; step(3);
        mask = 2'd2; step(3);
        mask = 2'd0; step(3);

        tag = "R8";
        lp = 1'b1; step(3);
        irq = '0; step(3);
        lp = 1'b0; step(2);

        tag = "R6";
        set_irq(40, -1, -1, -1);
        wr(82, 'h3FFF); step(2);
        wr(82, 0); step(2);

        // Same-cycle configuration write against a live winner
        tag = "R2";
        set_irq(40, 5, -1, -1);
        wr(40, 0); step(2);
        wr(5, 3); wr(82, 'h0155); step(3);

        tag = "R4";
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < NS; s++) irq[s] = ($urandom % 20) == 0;
            mask = 2'($urandom % 4);
            lp   = ($urandom % 3) == 0;
            if (($urandom % 4) == 0) begin
                we = 1'b1; addr = 7'($urandom % 90); wdata = 14'($urandom);
            end else we = 1'b0;
            step(1);
        end
        we = 1'b0; irq = '0;
        step(3);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule